// File: doc/BRIEF.md
# Key-Guarded Byte Store Controller

This block fronts a 256-byte nonvolatile byte store with four byte-wide registers reached over a simple write-strobe bus: an address register, a data register, a control register and a key register. The store is not part of the ordinary register space. Software reaches it only through these four registers. A read is a single control-register write. A write needs three things: a write-enable flag set earlier, the two key bytes written in order to the key register, and the write request in the very next register write.

A write holds the store busy for a programmable number of cycles, taken from an input port, before the byte is committed. Software may drop the write-enable flag at any time. If it does so during a write, the write is abandoned and an error flag is raised. The storage array is a behavioural synchronous model inside the block.

Register select codes are 0 address, 1 data, 2 control, 3 key. Control bits are 0 read request, 1 write request/in progress, 2 write enable, 3 write error, 7 memory select (0 selects this store). All other control bits read 0, and the key register reads 0.

Top module: `nvm_data_ctrl`

## Requirements
- R1: After reset the address, data and control registers read 0, and `wr_busy` and `wr_done` are 0.
- R2: Writing the control register with bit 0 set and bit 7 clear, while no write is in progress, sets bit 0. Bit 0 reads 1 for exactly two cycles and then clears itself. By the time it clears, the data register holds the stored byte at the address register.
- R3: A write begins only in this order: control bit 2 already 1, then 0x55 to the key register, then 0xAA to the key register, then a control write with bits 1 and 2 set and bit 7 clear as the next register write.
- R4: A key byte other than the expected one, or any register write between the key bytes and the write request, returns the key checker to its start, and the following write request is ignored (the store is unchanged and no busy time elapses).
- R5: A write request is ignored when control bit 2 was 0 before the request. Clearing bit 2 while idle is allowed and raises no error.
- R6: When control bit 7 is 1, read and write requests are ignored. The data register and the store are then unchanged.
- R7: Control bit 1 and `wr_busy` stay 1 for max(1, `cfg_wr_time`) cycles after the request. The byte is then committed to the store, and `wr_done` pulses for one cycle as bit 1 falls.
- R8: Clearing control bit 2 during a write ends it on the next edge without changing the store and sets control bit 3. Writing 0 to bit 3 clears the error.
- R9: While a write is in progress, writes to the address and data registers and to bit 7 are ignored, and read requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select (0 addr, 1 data, 2 ctrl, 3 key) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read-back of the selected register |
| cfg_wr_time | input | TIME_W | Write duration in cycles (0 treated as 1) |
| wr_busy | output | 1 | Write in progress |
| wr_done | output | 1 | One-cycle pulse when a write commits |

## Verification
The assertions assume that `bus_we` is a one-cycle strobe carrying a single register access, and that reset is held for at least one edge before checking starts. They make no assumption about `cfg_wr_time` beyond its width, because the counter samples it only when a write starts. The bench keeps to these assumptions by issuing one strobe at a time with an idle cycle between accesses. It changes `cfg_wr_time` only while the store is idle.

// File: rtl/nvm_pkg.sv
// Shared definitions for the key-guarded byte store controller.
// Assumes byte-wide register bus with a two-bit register select.
package nvm_pkg;
    typedef enum logic [1:0] {
        REG_ADDR = 2'd0,
        REG_DATA = 2'd1,
        REG_CTRL = 2'd2,
        REG_KEY  = 2'd3
    } reg_sel_e;

    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_ENA = 2;
    localparam int CB_ERR = 3;
    localparam int CB_SEL = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_HALF  = 2'd1,
        KS_ARMED = 2'd2
    } key_state_e;

    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_LOAD = 2'd1,
        RP_HOLD = 2'd2
    } rd_phase_e;
endpackage

// File: rtl/nvm_unlock.sv
// Key sequence checker: watches every register write and is armed only
// after the first key then the second key land back to back in the key
// register. Any other register write returns it to idle, including the
// write that consumes the armed state.
// Assumes bus_we is a single-cycle strobe per access.
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic       key_hit,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_state_e state_q, state_d;

    // Next-state decode of the key sequence.
    always_comb begin
        state_d = state_q;
        if (bus_we) begin
            unique case (state_q)
                KS_IDLE:  state_d = (key_hit && wdata == KEY_FIRST)  ? KS_HALF  : KS_IDLE;
                KS_HALF:  state_d = (key_hit && wdata == KEY_SECOND) ? KS_ARMED : KS_IDLE;
                KS_ARMED: state_d = KS_IDLE;
                default:  state_d = KS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == KS_ARMED);
endmodule

// File: rtl/nvm_wtimer.sv
// Write-duration counter: loads the programmed time on start (0 taken as 1),
// counts down while busy, and flags expiry on the last busy cycle unless
// the write is aborted in that same cycle.
// Assumes start is only raised while not busy.
module nvm_wtimer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [TIME_W-1:0] load_val,
    output logic              busy,
    output logic              expire
);
    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    logic [TIME_W-1:0] cnt_q;

    assign busy   = (cnt_q != '0);
    assign expire = busy && (cnt_q == ONE) && !abort;

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= (load_val == '0) ? ONE : load_val;
        else if (busy && abort)  cnt_q <= '0;
        else if (busy)           cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/nvm_array.sv
// Behavioural byte store: combinational read port, synchronous write port.
// Contents are not reset, as for a nonvolatile cell array.
module nvm_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Commit one byte.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_data_ctrl.sv
// Top of the key-guarded byte store controller. Holds the address, data and
// control registers, sequences reads in two phases, starts writes only when
// the key checker is armed, and commits bytes when the write timer expires.
// Assumes one register access per bus_we strobe; ADDR_W is at most 8.
module nvm_data_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [TIME_W-1:0] cfg_wr_time,
    output logic              wr_busy,
    output logic              wr_done
);
    reg_sel_e          sel_e;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              ena_q;
    logic              err_q;
    logic              msel_q;
    logic              done_q;
    rd_phase_e         rph_q;
    logic              rd_go;
    logic              key_armed;
    logic              ctrl_wr;
    logic              wr_start;
    logic              wr_abort;
    logic              rd_start;
    logic              tmr_busy;
    logic              tmr_expire;
    logic [7:0]        arr_rdata;

    assign sel_e   = reg_sel_e'(bus_sel);
    assign ctrl_wr = bus_we && (sel_e == REG_CTRL);
    assign rd_go   = (rph_q != RP_IDLE);

    // Request decode for read, write start and write abort.
    always_comb begin
        rd_start = ctrl_wr && bus_wdata[CB_RD] && !bus_wdata[CB_SEL]
                   && !tmr_busy && !rd_go;
        wr_start = ctrl_wr && key_armed && bus_wdata[CB_WR] && bus_wdata[CB_ENA]
                   && ena_q && !bus_wdata[CB_SEL] && !tmr_busy && !rd_go;
        wr_abort = ctrl_wr && !bus_wdata[CB_ENA] && tmr_busy;
    end

    nvm_unlock u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_we  (bus_we),
        .key_hit (sel_e == REG_KEY),
        .wdata   (bus_wdata),
        .armed   (key_armed)
    );

    nvm_wtimer #(.TIME_W(TIME_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .abort    (wr_abort),
        .load_val (cfg_wr_time),
        .busy     (tmr_busy),
        .expire   (tmr_expire)
    );

    nvm_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .we    (tmr_expire),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    // Address register: frozen while a write is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (bus_we && sel_e == REG_ADDR && !tmr_busy)
            addr_q <= ADDR_W'(bus_wdata);
    end

    // Data register: loaded by software, or by the load phase of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (rph_q == RP_LOAD)
            data_q <= arr_rdata;
        else if (bus_we && sel_e == REG_DATA && !tmr_busy)
            data_q <= bus_wdata;
    end

    // Read phase sequencer: load, hold, then self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) rph_q <= RP_IDLE;
        else begin
            unique case (rph_q)
                RP_IDLE: if (rd_start) rph_q <= RP_LOAD;
                RP_LOAD: rph_q <= RP_HOLD;
                RP_HOLD: rph_q <= RP_IDLE;
                default: rph_q <= RP_IDLE;
            endcase
        end
    end

    // Control flags: enable, memory select and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q  <= 1'b0;
            msel_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (ctrl_wr) begin
            ena_q <= bus_wdata[CB_ENA];
            if (!tmr_busy) msel_q <= bus_wdata[CB_SEL];
            if (wr_abort)               err_q <= 1'b1;
            else if (!bus_wdata[CB_ERR]) err_q <= 1'b0;
        end
    end

    // Completion pulse, one cycle after the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= tmr_expire;
    end

    // Register read-back mux.
    always_comb begin
        unique case (sel_e)
            REG_ADDR: bus_rdata = 8'(addr_q);
            REG_DATA: bus_rdata = data_q;
            REG_CTRL: bus_rdata = {msel_q, 3'b000, err_q, ena_q, tmr_busy, rd_go};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign wr_busy = tmr_busy;
    assign wr_done = done_q;
endmodule

// File: rtl/nvm_data_ctrl_chk.sv
// Property checker for nvm_data_ctrl, attached by bind below.
// Assumes bus_we strobes one access per cycle and reset is synchronous.
module nvm_data_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_busy,
    input logic              wr_done,
    input logic              rd_go,
    input logic              err,
    input logic              armed,
    input logic              msel,
    input logic [ADDR_W-1:0] addr_q
);
    AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(armed)); // R3
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ($past(wr_busy) && !wr_busy)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done); // R7
    AST_ERR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(wr_busy) && !wr_busy)); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && $past(wr_busy)) |-> $stable(addr_q)); // R9
    AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_go && wr_busy)); // R9
    AST_READ_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && $past(rd_go)) |=> !rd_go); // R2
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_go) |=> rd_go); // R2
    AST_NO_READ_SELECTED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_go) |-> !msel); // R6
endmodule

bind nvm_data_ctrl nvm_data_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_busy (wr_busy),
    .wr_done (wr_done),
    .rd_go   (rd_go),
    .err     (err_q),
    .armed   (key_armed),
    .msel    (msel_q),
    .addr_q  (addr_q)
);

// File: tb/tb_nvm_data_ctrl.sv
module tb_nvm_data_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TIME_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_sel = 2'd0;
    logic [7:0]        bus_wdata = 8'd0;
    logic [7:0]        bus_rdata;
    logic [TIME_W-1:0] cfg_wr_time = '0;
    logic              wr_busy;
    logic              wr_done;

    int total = 0;
    int bad = 0;

    nvm_data_ctrl #(.ADDR_W(8), .TIME_W(TIME_W)) dut (
        .clk, .rst_n, .bus_we, .bus_sel, .bus_wdata, .bus_rdata,
        .cfg_wr_time, .wr_busy, .wr_done
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One register write strobe; returns at the falling edge after it lands.
    task automatic bw(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic [7:0] peek(input logic [1:0] s);
        bus_sel = s;
        return bus_rdata;
    endfunction

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
        bus_sel = s;
        #1 v = bus_rdata;
    endtask

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 7 + 3 + k * 29) & 255);
    endfunction

    task automatic unlock_and_go(input logic [7:0] go);
        bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd2, go);
    endtask

    // Waits out a write, returns busy length and whether done pulsed at the end.
    task automatic wait_write(output int len, output bit done_seen);
        len = wr_busy ? 1 : 0;
        done_seen = 1'b0;
        if (wr_busy) begin
            while (1) begin
                @(negedge clk);
                if (wr_busy) len++;
                else begin done_seen = wr_done; break; end
            end
        end
    endtask

    task automatic store(input int a, input logic [7:0] d, output int len, output bit dn);
        bw(2'd0, 8'(a)); bw(2'd1, d); bw(2'd2, 8'h04);
        unlock_and_go(8'h06);
        wait_write(len, dn);
    endtask

    task automatic fetch(input int a, output logic [7:0] v, output bit seq_ok);
        logic [7:0] c1, c2, c3;
        bw(2'd0, 8'(a)); bw(2'd2, 8'h01);
        rd_reg(2'd2, c1);
        @(negedge clk); rd_reg(2'd2, c2);
        @(negedge clk); rd_reg(2'd2, c3);
        seq_ok = c1[0] && c2[0] && !c3[0];
        rd_reg(2'd1, v);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v, c;
        int len; bit dn, sok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd_reg(2'd0, v); check(v == 0, "R1 addr", v, 0);
        rd_reg(2'd1, v); check(v == 0, "R1 data", v, 0);
        rd_reg(2'd2, v); check(v == 0, "R1 ctrl", v, 0);
        check(!wr_busy && !wr_done, "R1 busy/done", {wr_busy, wr_done}, 0);

        // R3 R7 fill every address, R2 read each back
        cfg_wr_time = 16'd1;
        for (int a = 0; a < 256; a++) begin
            store(a, pat(a, 0), len, dn);
            if (len != 1 || !dn) check(0, "R7 fill length/done", len, 1);
        end
        total++;
        for (int a = 0; a < 256; a++) begin
            fetch(a, v, sok);
            check(v == pat(a, 0), "R2 readback", v, pat(a, 0));
            if (!sok) check(0, "R2 read bit timing", 0, 1);
        end

        // R7 busy length sweep including zero
        for (int t = 0; t < 8; t++) begin
            cfg_wr_time = 16'(t);
            store(t, pat(t, 1), len, dn);
            check(len == ((t == 0) ? 1 : t), "R7 busy cycles", len, (t == 0) ? 1 : t);
            check(dn, "R7 done pulse", dn, 1);
            fetch(t, v, sok);
            check(v == pat(t, 1), "R7 committed byte", v, pat(t, 1));
        end
        cfg_wr_time = 16'd3;

        // R4 wrong second key
        bw(2'd0, 8'd10); bw(2'd1, 8'hEE); bw(2'd2, 8'h04);
        bw(2'd3, 8'h55); bw(2'd3, 8'hAB); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
        check(!wr_busy, "R4 bad key no busy", wr_busy, 0);
        // R4 wrong first key
        bw(2'd2, 8'h04); bw(2'd3, 8'h54); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
        check(!wr_busy, "R4 bad first key", wr_busy, 0);
        // R4 intervening write
        bw(2'd2, 8'h04); bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd1, 8'hEE); bw(2'd2, 8'h06);
        check(!wr_busy, "R4 intervening access", wr_busy, 0);
        fetch(10, v, sok);
        check(v == pat(10, 0), "R4 store untouched", v, pat(10, 0));

        // R5 enable not set beforehand
        bw(2'd0, 8'd11); bw(2'd1, 8'hEE); bw(2'd2, 8'h00);
        unlock_and_go(8'h06);
        check(!wr_busy, "R5 no enable no write", wr_busy, 0);
        fetch(11, v, sok);
        check(v == pat(11, 0), "R5 store untouched", v, pat(11, 0));
        bw(2'd2, 8'h04); bw(2'd2, 8'h00);
        rd_reg(2'd2, c); check(c == 8'h00, "R5 idle clear no error", c, 0);

        // R6 memory select off
        bw(2'd0, 8'd12); bw(2'd1, 8'h3C); bw(2'd2, 8'h81);
        rd_reg(2'd2, c); check(c == 8'h80, "R6 read ignored", c, 8'h80);
        rd_reg(2'd1, v); check(v == 8'h3C, "R6 data unchanged", v, 8'h3C);
        bw(2'd2, 8'h84); unlock_and_go(8'h86);
        check(!wr_busy, "R6 write ignored", wr_busy, 0);
        bw(2'd2, 8'h00);
        fetch(12, v, sok);
        check(v == pat(12, 0), "R6 store untouched", v, pat(12, 0));

        // R9 frozen registers during write
        cfg_wr_time = 16'd20;
        bw(2'd0, 8'd13); bw(2'd1, 8'h5A); bw(2'd2, 8'h04); unlock_and_go(8'h06);
        check(wr_busy, "R9 write started", wr_busy, 1);
        bw(2'd0, 8'd99); bw(2'd1, 8'h11); bw(2'd2, 8'h85);
        rd_reg(2'd0, v); check(v == 8'd13, "R9 addr frozen", v, 13);
        rd_reg(2'd1, v); check(v == 8'h5A, "R9 data frozen", v, 8'h5A);
        rd_reg(2'd2, c); check(c == 8'h06, "R9 read/select ignored", c, 8'h06);
        wait_write(len, dn);
        check(dn, "R9 write completes", dn, 1);
        fetch(13, v, sok);
        check(v == 8'h5A, "R9 committed", v, 8'h5A);

        // R8 abort during write
        bw(2'd0, 8'd14); bw(2'd1, 8'hC3); bw(2'd2, 8'h04); unlock_and_go(8'h06);
        repeat (3) @(negedge clk);
        bw(2'd2, 8'h00);
        check(!wr_busy, "R8 abort ends write", wr_busy, 0);
        rd_reg(2'd2, c); check(c == 8'h08, "R8 error set", c, 8'h08);
        repeat (25) @(negedge clk);
        check(!wr_done, "R8 no done after abort", wr_done, 0);
        bw(2'd2, 8'h00);
        rd_reg(2'd2, c); check(c == 8'h00, "R8 error cleared", c, 0);
        fetch(14, v, sok);
        check(v == pat(14, 0), "R8 store untouched", v, pat(14, 0));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule